// File: doc/BRIEF.md
# Dual-Port Collision Busy Arbiter

This block sits beside a shared two-port memory array and watches both ports every clock. When both ports are enabled and present the same word address, it lets one of them proceed and raises an active-low busy flag toward the other. Any write from the flagged port is then suppressed before it reaches the array. The decision uses only each port's enable and address. Whether an access is a read or a write has no effect on who wins.

A mode input selects the block's role. In master mode the block arbitrates and actively drives both busy outputs. In slave mode it makes no decision and drives both busy outputs high. Each port then takes a separate busy input, driven from a master slice, and uses it purely as a write inhibit. This lets several slices share one master's decision when the memory is widened, so the slices cannot disagree.

Enable, address, write enable and the busy inputs are sampled on the rising clock edge. The busy output and the gated write strobe both reflect the inputs sampled at the previous edge. The busy flag is therefore valid while the write is still pending, and the array commits the gated write on the following edge.

Top module: `dp_collision_arbiter`

## Requirements
- R1: While reset (rstN low) is asserted, and directly after it, both busy outputs are high and both gated write outputs are low.
- R2: In master mode, when both enables are high and the addresses are equal at a clock edge, exactly one busy output is low after that edge. Otherwise, both busy outputs are high after that edge.
- R3: When a collision starts with both ports arriving at the same edge, the left port wins and the right busy output goes low.
- R4: When one port was already enabled at an address and the other port arrives there later, the port that was there first wins and the newcomer is flagged busy.
- R5: The winner keeps its grant for as long as the collision persists and the winner's enable and address stay unchanged. When its enable drops or its address changes, and the collision ends as a result, both busy outputs return high.
- R6: A port's gated write output is high only if that port's enable and write enable were both high at the previous edge and the port is not inhibited. In master mode, a busy-flagged port is inhibited.
- R7: Read accesses (write enable low) collide and are flagged exactly as write accesses are.
- R8: In master mode, the busy input pins have no effect. Writes pass whatever level the busy inputs are held at.
- R9: In slave mode (masterMode low), both busy outputs stay high even during a collision. A port whose busy input was high at the previous edge writes normally.
- R10: In slave mode, a port whose busy input was low at the previous edge has its gated write output held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| masterMode | input | 1 | 1 = arbitrate and drive busy outputs; 0 = busy inputs act as write inhibits |
| leftEn | input | 1 | Left port enable |
| leftAddr | input | ADDR_W | Left port word address |
| leftWe | input | 1 | Left port write enable (1 = write) |
| leftBusyInN | input | 1 | Left external write inhibit, active low, used in slave mode |
| leftBusyN | output | 1 | Left busy flag, active low, driven in master mode |
| leftWeGated | output | 1 | Left write strobe toward the array after inhibit |
| rightEn | input | 1 | Right port enable |
| rightAddr | input | ADDR_W | Right port word address |
| rightWe | input | 1 | Right port write enable (1 = write) |
| rightBusyInN | input | 1 | Right external write inhibit, active low, used in slave mode |
| rightBusyN | output | 1 | Right busy flag, active low, driven in master mode |
| rightWeGated | output | 1 | Right write strobe toward the array after inhibit |

## Verification
Two things can happen in the same cycle: a collision is decided, and a write from one of the colliding ports is gated. The bench provokes this by driving both ports to one address with both write enables high, both on the same edge and on staggered edges. It also holds and moves the winner's address, and flips the mode in the middle of a collision. A behavioural model, updated on every rising edge, predicts each port's busy and gated write levels. The outputs are compared at every falling edge, so a wrong winner or a write that leaks past its busy flag shows up in the cycle where it occurs.

// File: rtl/dp_arb_pkg.sv
package dp_arb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } ownerT;

  // Datapath -> control: comparison results for the current inputs.
  typedef struct packed {
    logic       collide;
    logic [1:0] stay;     // port kept enable and address since last edge
  } matchT;

  // Control -> datapath: per-port busy strobes (index 0 = left, 1 = right).
  typedef struct packed {
    logic [1:0] busy;
  } strobeT;
endpackage

// File: rtl/dp_arb_datapath.sv
module dp_arb_datapath
  import dp_arb_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int NPORT = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          masterMode,
  input  logic [NPORT-1:0]              portEn,
  input  logic [NPORT-1:0][ADDR_W-1:0]  portAddr,
  input  logic [NPORT-1:0]              portWe,
  input  logic [NPORT-1:0]              portBusyInN,
  input  strobeT                        strobes,
  output matchT                         match,
  output logic [NPORT-1:0]              portWeGated
);
  logic [NPORT-1:0]             enQ;
  logic [NPORT-1:0][ADDR_W-1:0] addrQ;
  logic [NPORT-1:0]             weQ;
  logic [NPORT-1:0]             busyInNQ;
  logic [NPORT-1:0]             inhibit;

  assign match.collide = portEn[0] & portEn[1] & (portAddr[0] == portAddr[1]);

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enQ[i]      <= 1'b0;
        addrQ[i]    <= '0;
        weQ[i]      <= 1'b0;
        busyInNQ[i] <= 1'b1;
      end else begin
        enQ[i]      <= portEn[i];
        addrQ[i]    <= portAddr[i];
        weQ[i]      <= portWe[i];
        busyInNQ[i] <= portBusyInN[i];
      end
    end

    assign match.stay[i]  = enQ[i] & portEn[i] & (addrQ[i] == portAddr[i]);
    assign inhibit[i]     = masterMode ? strobes.busy[i] : ~busyInNQ[i];
    assign portWeGated[i] = enQ[i] & weQ[i] & ~inhibit[i];
  end
endmodule

// File: rtl/dp_arb_ctrl.sv
module dp_arb_ctrl
  import dp_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   masterMode,
  input  matchT  match,
  output strobeT strobes
);
  ownerT owner, ownerNext;

  always_comb begin
    ownerNext = OWN_NONE;
    if (masterMode && match.collide) begin
      if (owner == OWN_LEFT && match.stay[0])
        ownerNext = OWN_LEFT;
      else if (owner == OWN_RIGHT && match.stay[1])
        ownerNext = OWN_RIGHT;
      else if (match.stay[1] && !match.stay[0])
        ownerNext = OWN_RIGHT;   // right was there first
      else
        ownerNext = OWN_LEFT;    // simultaneous arrival: left wins
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) owner <= OWN_NONE;
    else       owner <= ownerNext;
  end

  assign strobes.busy[0] = masterMode && (owner == OWN_RIGHT);
  assign strobes.busy[1] = masterMode && (owner == OWN_LEFT);

  // R5: a winner that stays put through an ongoing collision keeps the grant
  p_winner_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && owner == OWN_LEFT && match.collide && match.stay[0])
      |=> (owner == OWN_LEFT || !$past(masterMode)));
endmodule

// File: rtl/dp_collision_arbiter.sv
module dp_collision_arbiter
  import dp_arb_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              leftEn,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              leftWe,
  input  logic              leftBusyInN,
  output logic              leftBusyN,
  output logic              leftWeGated,
  input  logic              rightEn,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              rightWe,
  input  logic              rightBusyInN,
  output logic              rightBusyN,
  output logic              rightWeGated
);
  matchT      match;
  strobeT     strobes;
  logic [1:0] weGated;

  dp_arb_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .masterMode  (masterMode),
    .portEn      ({rightEn, leftEn}),
    .portAddr    ({rightAddr, leftAddr}),
    .portWe      ({rightWe, leftWe}),
    .portBusyInN ({rightBusyInN, leftBusyInN}),
    .strobes     (strobes),
    .match       (match),
    .portWeGated (weGated)
  );

  dp_arb_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .masterMode (masterMode),
    .match      (match),
    .strobes    (strobes)
  );

  assign leftBusyN    = ~strobes.busy[0];
  assign rightBusyN   = ~strobes.busy[1];
  assign leftWeGated  = weGated[0];
  assign rightWeGated = weGated[1];

  // R2: never both flagged
  p_single_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(!leftBusyN && !rightBusyN));

  // R2: a busy flag needs a collision in master mode at the previous edge
  p_busy_needs_collision_r2: assert property (@(posedge clk) disable iff (!rstN)
    !leftBusyN |-> $past(masterMode && leftEn && rightEn && leftAddr == rightAddr));

  // R6: a flagged port never writes
  p_busy_blocks_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!leftBusyN |-> !leftWeGated) and (!rightBusyN |-> !rightWeGated));

  // R9: slave mode drives busy outputs high
  p_slave_busy_high_r9: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |-> (leftBusyN && rightBusyN));

  // R10: low busy input in slave mode blocks that port's write
  p_slave_inhibit_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!masterMode && $past(!leftBusyInN)) |-> !leftWeGated);
endmodule

// File: tb/sim_dp_collision_arbiter.sv
module sim_dp_collision_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterMode = 1'b1;
  logic lEn = 0, lWe = 0, lBin = 1, rEn = 0, rWe = 0, rBin = 1;
  logic [AW-1:0] lAddr = '0, rAddr = '0;
  logic lBusyN, lWeG, rBusyN, rWeG;

  int checks = 0, failures = 0;
  string tag = "R1";
  bit done = 0;

  // behavioural model state
  int mEn[2], mAddr[2], mWe[2], mBin[2], mOwner[$];

  dp_collision_arbiter #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .masterMode(masterMode),
    .leftEn(lEn), .leftAddr(lAddr), .leftWe(lWe), .leftBusyInN(lBin),
    .leftBusyN(lBusyN), .leftWeGated(lWeG),
    .rightEn(rEn), .rightAddr(rAddr), .rightWe(rWe), .rightBusyInN(rBin),
    .rightBusyN(rBusyN), .rightWeGated(rWeG)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial mOwner.push_back(0);

  always @(posedge clk or negedge rstN) begin
    int cur, nxt;
    bit col, lStay, rStay;
    if (!rstN) begin
      for (int i = 0; i < 2; i++) begin mEn[i] = 0; mAddr[i] = 0; mWe[i] = 0; mBin[i] = 1; end
      mOwner[0] = 0;
    end else begin
      cur = mOwner[0];
      col = lEn && rEn && (lAddr == rAddr);
      lStay = (mEn[0] == 1) && lEn && (mAddr[0] == int'(lAddr));
      rStay = (mEn[1] == 1) && rEn && (mAddr[1] == int'(rAddr));
      nxt = 0;
      if (masterMode && col) begin
        if (cur == 1 && lStay) nxt = 1;
        else if (cur == 2 && rStay) nxt = 2;
        else if (rStay && !lStay) nxt = 2;
        else nxt = 1;
      end
      mOwner[0] = nxt;
      mEn[0] = lEn; mAddr[0] = int'(lAddr); mWe[0] = lWe; mBin[0] = lBin;
      mEn[1] = rEn; mAddr[1] = int'(rAddr); mWe[1] = rWe; mBin[1] = rBin;
    end
  end

  task automatic cmp(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    logic eb0, eb1, ew0, ew1, inh0, inh1;
    eb0 = !(masterMode && mOwner[0] == 2);
    eb1 = !(masterMode && mOwner[0] == 1);
    inh0 = masterMode ? !eb0 : (mBin[0] == 0);
    inh1 = masterMode ? !eb1 : (mBin[1] == 0);
    ew0 = (mEn[0] == 1) && (mWe[0] == 1) && !inh0;
    ew1 = (mEn[1] == 1) && (mWe[1] == 1) && !inh1;
    cmp("leftBusyN", lBusyN, eb0);
    cmp("rightBusyN", rBusyN, eb1);
    cmp("leftWeGated", lWeG, ew0);
    cmp("rightWeGated", rWeG, ew1);
  endtask

  task automatic step(logic le, logic [AW-1:0] la, logic lw, logic lb,
                      logic re, logic [AW-1:0] ra, logic rw, logic rb);
    lEn = le; lAddr = la; lWe = lw; lBin = lb;
    rEn = re; rAddr = ra; rWe = rw; rBin = rb;
    @(negedge clk);
    checkAll();
  endtask

  task automatic expectBusy(string what, logic act, logic exp);
    cmp(what, act, exp);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    // R1: reset state, inputs active during reset
    lEn = 1; lWe = 1; rEn = 1; rWe = 1;
    repeat (3) begin @(negedge clk); checkAll(); end
    rstN = 1;
    step(0, 0, 0, 1, 0, 0, 0, 1);
    expectBusy("R1 leftBusyN after reset", lBusyN, 1'b1);

    // R8: no collision, writes pass in master mode
    tag = "R8";
    step(1, 16'h0005, 1, 1, 1, 16'h0006, 1, 1);
    step(1, 16'h0007, 1, 1, 0, 16'h0007, 1, 1);

    // R3/R6: both arrive at once -> right flagged, right write blocked
    tag = "R3";
    step(0, 0, 0, 1, 0, 0, 0, 1);
    step(1, 16'h1234, 1, 1, 1, 16'h1234, 1, 1);
    expectBusy("R3 rightBusyN", rBusyN, 1'b0);
    tag = "R6";
    expectBusy("R6 rightWeGated blocked", rWeG, 1'b0);
    expectBusy("R6 leftWeGated passes", lWeG, 1'b1);

    // R5: winner holds, then moves away
    tag = "R5";
    step(1, 16'h1234, 1, 1, 1, 16'h1234, 1, 1);
    step(1, 16'h1234, 0, 1, 1, 16'h1234, 1, 1);
    expectBusy("R5 right still busy", rBusyN, 1'b0);
    step(1, 16'h1235, 1, 1, 1, 16'h1234, 1, 1);
    expectBusy("R5 busy cleared", rBusyN, 1'b1);

    // R4: left comes back where right has stayed -> left is newcomer
    tag = "R4";
    step(1, 16'h1234, 1, 1, 1, 16'h1234, 1, 1);
    expectBusy("R4 leftBusyN", lBusyN, 1'b0);
    expectBusy("R4 leftWeGated", lWeG, 1'b0);
    step(0, 0, 0, 1, 1, 16'h0009, 0, 1);
    step(1, 16'h0009, 1, 1, 1, 16'h0009, 1, 1);
    expectBusy("R4 late left flagged", lBusyN, 1'b0);
    tag = "R5";
    step(1, 16'h0009, 1, 1, 1, 16'h0009, 1, 1);
    step(1, 16'h0009, 1, 1, 0, 16'h0009, 1, 1);
    expectBusy("R5 enable drop clears", lBusyN, 1'b1);

    // R7: reads collide identically
    tag = "R7";
    step(0, 0, 0, 1, 0, 0, 0, 1);
    step(1, 16'h00AA, 0, 1, 1, 16'h00AA, 0, 1);
    expectBusy("R7 read collision flags right", rBusyN, 1'b0);
    step(1, 16'h00AA, 0, 1, 1, 16'h00AA, 1, 1);

    // R2: distinct address patterns, none collide
    tag = "R2";
    for (int k = 0; k < 8; k++)
      step(1, AW'(k * 3), k[0], 1, 1, AW'(k * 3 + 1), 1, 1);
    step(1, 16'hFFFF, 1, 1, 1, 16'hFFFF, 1, 1);
    expectBusy("R2 collision at top address", rBusyN, 1'b0);

    // R8: busy inputs low in master mode have no effect
    tag = "R8";
    step(1, 16'h0100, 1, 0, 1, 16'h0200, 1, 0);
    expectBusy("R8 left write passes", lWeG, 1'b1);
    expectBusy("R8 right write passes", rWeG, 1'b1);

    // R9: slave mode, collision but busy outputs stay high
    tag = "R9";
    step(1, 16'h0300, 1, 1, 1, 16'h0300, 1, 1);
    masterMode = 0;
    @(negedge clk); checkAll();
    step(1, 16'h0300, 1, 1, 1, 16'h0300, 1, 1);
    expectBusy("R9 leftWeGated", lWeG, 1'b1);
    expectBusy("R9 rightWeGated", rWeG, 1'b1);

    // R10: busy input low blocks writes in slave mode
    tag = "R10";
    step(1, 16'h0300, 1, 0, 1, 16'h0300, 1, 1);
    expectBusy("R10 left blocked", lWeG, 1'b0);
    step(1, 16'h0400, 1, 1, 1, 16'h0401, 1, 0);
    expectBusy("R10 right blocked", rWeG, 1'b0);
    step(1, 16'h0400, 1, 1, 1, 16'h0401, 1, 1);

    // back to master, collision resolves again
    tag = "R3";
    masterMode = 1;
    step(1, 16'h0500, 1, 1, 1, 16'h0500, 1, 1);
    step(0, 0, 0, 1, 0, 0, 0, 1);

    finishRun();
  end
endmodule